// File: doc/BRIEF.md
# Interval Timer Channel

This block is one countdown timer channel that raises a level interrupt once a programmed number of count events has passed. Software programs it through a small write port with two 32-bit registers: one holds the enable flag, the periodic flag and the count value, and the other reports the live remaining count and the pending flag and takes the interrupt clear. A separate combinational read port returns either register.

Each instance is built to count on one of two sources. It can count on every clock edge, or only on edges where a strobe input is high, for example a 1 MHz tick made from the oscillator. A loaded value N expires on the (N+1)-th count event. In periodic mode the channel reloads and keeps running. In one-shot mode it stops and drops its own enable flag.

Top module: `pit_channel`

## Requirements
- R1: After reset the interrupt output is low and both registers read as zero.
- R2: The control register is at byte offset 0x0. Bit 31 is enable, bit 30 is periodic mode, bits 28:0 are the count value, and bit 29 reads as zero. A read returns the last written fields, except that enable is cleared by a one-shot expiry.
- R3: A loaded value N sets the interrupt on the (N+1)-th count event after the load. While counting, the remaining count steps down by one on each count event.
- R4: The count field is 29 bits wide, so 0x1FFFFFFF is the largest value. Bit 29 of a written word is discarded.
- R5: Writing zero to the control register stops the channel, and the remaining count then holds.
- R6: The status register is at byte offset 0x4. Writing it with bit 30 set clears the pending interrupt. Writing it with bit 30 clear has no effect.
- R7: In periodic mode, an expiry reloads the programmed value and counting continues, so the interrupt sets again every N+1 count events.
- R8: In one-shot mode, an expiry clears the enable bit and the remaining count stays at zero.
- R9: With the parameter USE_TICK at 1, count events are the clock edges where tick_i is high. With USE_TICK at 0, every clock edge is a count event.
- R10: A control write while the channel runs restarts the countdown from the newly written value. A control write in the same cycle as a count event takes precedence over that event.
- R11: The pending flag stays set until cleared. When an expiry and a clear land in the same cycle, the flag stays set.
- R12: A status read returns the remaining count in bits 28:0, the pending flag in bit 30, and zeros elsewhere.
- R13: Writes to any offset other than 0x0 and 0x4 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count strobe, used when USE_TICK is 1 |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Write byte offset |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 4 | Read byte offset |
| reg_rdata | output | 32 | Read data, combinational |
| irq_o | output | 1 | Level interrupt, equal to the pending flag |

## Verification
A wrong remaining count shows in the status word one cycle after the count event that caused it. It then moves the interrupt edge away from the (N+1)-th event. A one-shot that fails to stop, or a periodic channel that reloads the wrong value, shows within one period as a count that does not match the bench model. A lost pending flag, or an enable flag stuck on after expiry, shows on the next read of irq_o or of the control word. The bench reads both registers after every cycle, so each fault is caught in the cycle it appears.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int DATA_W   = 32;
  localparam int OFS_CTRL = 0;
  localparam int OFS_STAT = 4;
  localparam int BIT_EN   = 31;
  localparam int BIT_PER  = 30;
  localparam int BIT_PEND = 30;
  localparam int BIT_CLR  = 30;

  typedef struct packed {
    logic run;
    logic per;
  } pit_mode_t;
endpackage

// File: rtl/pit_tick_sel.sv
module pit_tick_sel #(
  parameter bit USE_TICK = 1'b1
) (
  input  logic run_i,
  input  logic tick_i,
  output logic cnt_ev_o
);
  generate
    if (USE_TICK) begin : g_strobe
      assign cnt_ev_o = run_i & tick_i;
    end else begin : g_every_clk
      logic unused_tick;
      assign unused_tick = tick_i;
      assign cnt_ev_o    = run_i;
    end
  endgenerate
endmodule

// File: rtl/pit_down_counter.sv
module pit_down_counter #(
  parameter int CNT_W = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_we_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_val_i,
  input  logic             per_i,
  input  logic             cnt_ev_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_zero;

  assign at_zero  = (cnt_q == '0);
  assign expire_o = cnt_ev_i & at_zero;
  assign cnt_o    = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (load_we_i) begin
      cnt_d = load_val_i;
    end else if (cnt_ev_i) begin
      if (!at_zero)   cnt_d = cnt_q - 1'b1;
      else if (per_i) cnt_d = reload_val_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pit_ctrl_regs.sv
module pit_ctrl_regs
  import pit_pkg::*;
#(
  parameter int CNT_W  = 29,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_waddr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [ADDR_W-1:0] reg_raddr,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              expire_i,
  output logic              load_we_o,
  output logic [CNT_W-1:0]  reload_o,
  output pit_mode_t         mode_o,
  output logic              pend_o
);
  pit_mode_t        mode_q, mode_d;
  logic [CNT_W-1:0] reload_q, reload_d;
  logic             pend_q, pend_d;
  logic             clr_we;
  logic             unused_wbits;

  assign load_we_o    = reg_wr & (reg_waddr == ADDR_W'(OFS_CTRL));
  assign clr_we       = reg_wr & (reg_waddr == ADDR_W'(OFS_STAT)) & reg_wdata[BIT_CLR];
  assign unused_wbits = ^reg_wdata[BIT_PER-1:CNT_W];

  always_comb begin
    mode_d   = mode_q;
    reload_d = reload_q;
    if (load_we_o) begin
      mode_d.run = reg_wdata[BIT_EN];
      mode_d.per = reg_wdata[BIT_PER];
      reload_d   = reg_wdata[CNT_W-1:0];
    end else if (expire_i && !mode_q.per) begin
      mode_d.run = 1'b0;
    end
  end

  always_comb begin
    pend_d = pend_q;
    if (expire_i)    pend_d = 1'b1;
    else if (clr_we) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      reload_q <= '0;
      pend_q   <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      reload_q <= reload_d;
      pend_q   <= pend_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_raddr == ADDR_W'(OFS_CTRL)) begin
      reg_rdata[BIT_EN]      = mode_q.run;
      reg_rdata[BIT_PER]     = mode_q.per;
      reg_rdata[CNT_W-1:0]   = reload_q;
    end else if (reg_raddr == ADDR_W'(OFS_STAT)) begin
      reg_rdata[BIT_PEND]    = pend_q;
      reg_rdata[CNT_W-1:0]   = cnt_i;
    end
  end

  assign reload_o = reload_q;
  assign mode_o   = mode_q;
  assign pend_o   = pend_q;
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int CNT_W    = 29,
  parameter int ADDR_W   = 4,
  parameter bit USE_TICK = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_waddr,
  input  logic [31:0]       reg_wdata,
  input  logic [ADDR_W-1:0] reg_raddr,
  output logic [31:0]       reg_rdata,
  output logic              irq_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             load_we;
  logic [CNT_W-1:0] reload_val;
  logic [CNT_W-1:0] cnt;
  logic             cnt_ev;
  logic             expire;
  pit_mode_t        mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pit_ctrl_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .reg_wr    (reg_wr),
    .reg_waddr (reg_waddr),
    .reg_wdata (reg_wdata),
    .reg_raddr (reg_raddr),
    .reg_rdata (reg_rdata),
    .cnt_i     (cnt),
    .expire_i  (expire),
    .load_we_o (load_we),
    .reload_o  (reload_val),
    .mode_o    (mode),
    .pend_o    (irq_o)
  );

  pit_tick_sel #(.USE_TICK(USE_TICK)) u_tick (
    .run_i    (mode.run),
    .tick_i   (tick_i),
    .cnt_ev_o (cnt_ev)
  );

  pit_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .load_we_i    (load_we),
    .load_val_i   (reg_wdata[CNT_W-1:0]),
    .reload_val_i (reload_val),
    .per_i        (mode.per),
    .cnt_ev_i     (cnt_ev),
    .cnt_o        (cnt),
    .expire_o     (expire)
  );
endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk #(
  parameter int CNT_W  = 29,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_waddr,
  input logic [31:0]       reg_wdata,
  input logic              irq_o,
  input logic              expire,
  input logic              run,
  input logic              per,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  reload_val
);
  logic ld_wr, clr_wr;
  assign ld_wr  = reg_wr && (reg_waddr == ADDR_W'(0));
  assign clr_wr = reg_wr && (reg_waddr == ADDR_W'(4)) && reg_wdata[30];

  // R11
  a_r11_expiry_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> irq_o);
  // R6
  a_r6_clear_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !expire) |=> !irq_o);
  // R8
  a_r8_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !per && !ld_wr) |=> (!run && cnt == '0));
  // R5
  a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ld_wr) |=> $stable(cnt));
  // R7
  a_r7_periodic_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && per && !ld_wr) |=> (cnt == $past(reload_val)));
  // R10
  a_r10_write_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    ld_wr |=> (cnt == $past(reg_wdata[CNT_W-1:0])));
endmodule

bind pit_channel pit_channel_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .reg_wr     (reg_wr),
  .reg_waddr  (reg_waddr),
  .reg_wdata  (reg_wdata),
  .irq_o      (irq_o),
  .expire     (expire),
  .run        (mode.run),
  .per        (mode.per),
  .cnt        (cnt),
  .reload_val (reload_val)
);

// File: tb/pit_channel_bench.sv
module pit_channel_bench;
  localparam int CLK_P = 10;

  logic        clk;
  logic        rst_n;
  logic        tick;
  logic        reg_wr;
  logic [3:0]  reg_waddr;
  logic [31:0] reg_wdata;
  logic [3:0]  reg_raddr;
  logic [31:0] rdata, rdata_clk;
  logic        irq, irq_clk;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // reference state
  bit        m_en, m_per, m_pend;
  bit [28:0] m_load, m_cnt;

  pit_channel #(.USE_TICK(1'b1)) u_pit_channel (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .reg_wr(reg_wr),
    .reg_waddr(reg_waddr), .reg_wdata(reg_wdata), .reg_raddr(reg_raddr),
    .reg_rdata(rdata), .irq_o(irq));

  pit_channel #(.USE_TICK(1'b0)) u_pit_channel_clk (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .reg_wr(reg_wr),
    .reg_waddr(reg_waddr), .reg_wdata(reg_wdata), .reg_raddr(reg_raddr),
    .reg_rdata(rdata_clk), .irq_o(irq_clk));

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  function automatic logic [31:0] exp_ctrl();
    return {m_en, m_per, 1'b0, m_load};
  endfunction

  function automatic logic [31:0] exp_stat();
    return {1'b0, m_pend, 1'b0, m_cnt};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model(bit wr, bit [3:0] a, bit [31:0] d, bit tk);
    bit ev, ex;
    ev = m_en && tk;
    ex = ev && (m_cnt == 0);
    if (wr && a == 4'h0) begin
      m_en = d[31]; m_per = d[30]; m_load = d[28:0]; m_cnt = d[28:0];
    end else if (ev) begin
      if (m_cnt != 0) m_cnt = m_cnt - 1;
      else if (m_per) m_cnt = m_load;
      else m_en = 0;
    end
    if (ex) m_pend = 1;
    else if (wr && a == 4'h4 && d[30]) m_pend = 0;
  endtask

  // one clock: drive, update reference, then read both registers
  task automatic step(string tag, bit wr, bit [3:0] a, bit [31:0] d, bit tk);
    reg_wr = wr; reg_waddr = a; reg_wdata = d; tick = tk;
    @(posedge clk);
    model(wr, a, d, tk);
    @(negedge clk);
    reg_wr = 1'b0; tick = 1'b0;
    reg_raddr = 4'h0; #1;
    chk(tag, rdata, exp_ctrl());
    reg_raddr = 4'h4; #1;
    chk(tag, rdata, exp_stat());
    chk(tag, {31'b0, irq}, {31'b0, m_pend});
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0000_5eed));
    rst_n = 1'b0; tick = 1'b0; reg_wr = 1'b0; reg_waddr = '0;
    reg_wdata = '0; reg_raddr = '0;
    m_en = 0; m_per = 0; m_pend = 0; m_load = '0; m_cnt = '0;
    repeat (3) @(negedge clk);
    #1 chk("R1 ctrl in reset", rdata, 32'h0);
    chk("R1 irq in reset", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    reg_raddr = 4'h0; #1 chk("R1 ctrl after reset", rdata, 32'h0);
    reg_raddr = 4'h4; #1 chk("R1 stat after reset", rdata, 32'h0);

    // R2 R4: all ones, bit 29 dropped; R12 count readback
    step("R2 R4 full word", 1, 4'h0, 32'hFFFF_FFFF, 0);
    chk("R4 max value", exp_ctrl(), 32'hDFFF_FFFF);
    step("R3 R4 first tick", 0, 4'h0, 0, 1);
    step("R12 status count", 0, 4'h0, 0, 1);
    // R5 stop by zero write
    step("R5 stop", 1, 4'h0, 32'h0, 0);
    for (int i = 0; i < 4; i++) step("R5 held", 0, 4'h0, 0, 1);

    // R3 R8 one-shot N=2: expiry on third tick
    step("R8 load oneshot", 1, 4'h0, 32'h8000_0002, 0);
    for (int i = 0; i < 2; i++) begin
      step("R3 counting", 0, 4'h0, 0, 1);
      chk("R3 no early irq", {31'b0, irq}, 32'h0);
    end
    step("R3 expiry", 0, 4'h0, 0, 1);
    chk("R3 irq at N+1", {31'b0, irq}, 32'h1);
    for (int i = 0; i < 3; i++) step("R8 stopped", 0, 4'h0, 0, 1);

    // R6 clear
    step("R6 clear bit off", 1, 4'h4, 32'hBFFF_FFFF, 0);
    chk("R6 no effect", {31'b0, irq}, 32'h1);
    step("R6 clear", 1, 4'h4, 32'h4000_0000, 0);
    chk("R6 cleared", {31'b0, irq}, 32'h0);

    // R7 periodic N=1
    step("R7 load periodic", 1, 4'h0, 32'hC000_0001, 0);
    for (int i = 0; i < 10; i++) begin
      step("R7 periodic", 0, 4'h0, 0, 1);
      if (irq) step("R7 ack", 1, 4'h4, 32'h4000_0000, 0);
    end

    // R11 periodic N=0 expires every tick, clear lands with expiry
    step("R11 load", 1, 4'h0, 32'hC000_0000, 0);
    step("R11 clear", 1, 4'h4, 32'h4000_0000, 0);
    step("R11 clear vs expiry", 1, 4'h4, 32'h4000_0000, 1);
    chk("R11 expiry wins", {31'b0, irq}, 32'h1);

    // R10 restart while running
    step("R10 load", 1, 4'h0, 32'h8000_000A, 0);
    for (int i = 0; i < 3; i++) step("R10 run", 0, 4'h0, 0, 1);
    step("R10 rewrite with tick", 1, 4'h0, 32'h8000_0005, 1);
    chk("R10 restart value", exp_stat() & 32'h1FFF_FFFF, 32'h5);

    // R13 other offsets ignored
    step("R13 write 0x8", 1, 4'h8, 32'hFFFF_FFFF, 0);
    step("R13 write 0xC", 1, 4'hC, 32'h0000_0000, 0);

    // R9 every-clock variant: N=3 expires on 4th clock, tick-mode holds
    step("R9 stop", 1, 4'h0, 32'h0, 0);
    step("R9 clear", 1, 4'h4, 32'h4000_0000, 0);
    step("R9 load", 1, 4'h0, 32'h8000_0003, 0);
    for (int i = 0; i < 3; i++) begin
      step("R9 no tick", 0, 4'h0, 0, 0);
      chk("R9 clk mode not yet", {31'b0, irq_clk}, 32'h0);
    end
    step("R9 no tick", 0, 4'h0, 0, 0);
    chk("R9 clk mode expiry", {31'b0, irq_clk}, 32'h1);
    chk("R9 tick mode idle", {31'b0, irq}, 32'h0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      bit        wr, tk;
      bit [3:0]  a;
      bit [31:0] d;
      int        sel;
      wr  = ($urandom_range(7) == 0);
      tk  = $urandom_range(1);
      sel = $urandom_range(2);
      a   = (sel == 0) ? 4'h0 : (sel == 1) ? 4'h4 : 4'h8;
      d   = $urandom;
      if (a == 4'h0) d = {($urandom_range(4) != 0), d[30:29], 25'b0, d[3:0]};
      step("R3 R7 R12 random", wr, a, d, tk);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule